// File: doc/BRIEF.md
# Card Management Register Block

This block holds the card-level control and status registers of a removable flash memory card. The registers sit in the attribute memory space of a PC-card style host bus. The host reaches them through a register-space select, an active-low low-byte card enable, output-enable and write-enable strobes, an address bus and the low data byte. Two registers accept writes only. The option register carries a soft-reset bit, and the configuration register carries a power-down bit. Neither can be read back at its own address.

Software sees both bits through a separate read-only status register at its own address. That register also reports the live ready/busy state of the memory devices, passed through a two-flop synchronizer, so that software can poll it. The block drives a reset line and a power-down line to the memory array. A soft reset always forces the power-down bit back to normal operation.

Write strobes are brought into the block clock domain, and a write takes effect on the rising edge of write-enable. Read data is driven combinationally while output-enable is held and the access is qualified.

Top module: `cmr_top`

## Requirements
- R1: Reset defaults. While `rst` is high, and on the clock edge that samples it, every register bit returns to 0, so `mem_rst` and `mem_pd` read 0. After reset, the status register reads 0 except for its ready bit.
- R2: Soft reset. A write to offset 4000h with data bit 7 set drives `mem_rst` high and keeps it high. A later write there with bit 7 clear drives it low.
- R3: Power-down. A write to offset 4002h with data bit 2 set drives `mem_pd` high, provided soft reset is not active. The same write with bit 2 clear drives it low.
- R4: Status register. A read at offset 4100h returns bit 7 = current soft-reset bit, bit 2 = current power-down bit and bit 0 = synchronized ready input. Bits 6..3 and bit 1 read 0.
- R5: Ready synchronizer. A change on `mem_rdy` shows in status bit 0 exactly two clock edges later, and not after one.
- R6: Unsupported bits. Bits 6..0 of a write to 4000h have no effect. So do all bits other than bit 2 of a write to 4002h.
- R7: Soft-reset precedence. Setting soft reset clears the power-down bit. Writes that try to set power-down are ignored while soft reset is 1.
- R8: Access qualification. Any register write is ignored when any of these holds: `host_reg_n` is high, `host_ce1_n` is high, or address bit 0 is 1. Writes to the status offset, and to any other address, are also ignored. Address bits above bit 15 must be zero for a match.
- R9: Bus drive. `host_d` is driven only while `host_oe_n` is low and the access is qualified as in R8. Otherwise it floats.
- R10: Write-only readback. A qualified read at 4000h or 4002h returns 00h.
- R11: Write timing. A write takes effect only after the rising edge of `host_we_n`. Holding `host_we_n` low changes nothing, and each rising edge counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Card reset, active high, sampled on `clk` |
| host_reg_n | input | 1 | Register (attribute) space select, active low |
| host_ce1_n | input | 1 | Low-byte card enable, active low |
| host_oe_n | input | 1 | Host output-enable strobe, active low |
| host_we_n | input | 1 | Host write-enable strobe, active low |
| host_addr | input | ADDR_W | Host address, bit 0 must be 0 for register access |
| host_d | inout | 8 | Low data byte of the host bus |
| mem_rdy | input | 1 | Combined ready/busy of the memory devices, 1 = ready |
| mem_rst | output | 1 | Reset to the memory devices, high while soft reset is set |
| mem_pd | output | 1 | Power-down to the memory devices, active high |

## Verification
Directed writes are made with single set bits, with all other bits set, and with the control bit clear. These tell the one live bit of each register apart from the ignored ones. Writes repeated with one qualifier off at a time (register select, card enable, A0, a neighbouring offset, a high address bit) show that only a fully qualified access lands. The ordering of soft reset and power-down writes shows precedence, and a ready toggle sampled one and two edges later pins the synchronizer latency. A seeded random stream of mixed offsets, data and qualifiers, with ready changes in between, is checked against a bench model through both the output pins and the status readback.

// File: rtl/cmr_pkg.sv
`timescale 1ns/1ps
package cmr_pkg;

    localparam int unsigned OFS_W = 16;

    localparam logic [OFS_W-1:0] OFS_OPTION  = 16'h4000;
    localparam logic [OFS_W-1:0] OFS_CFGSTAT = 16'h4002;
    localparam logic [OFS_W-1:0] OFS_STATUS  = 16'h4100;

    localparam int unsigned OPT_SRST_BIT = 7;
    localparam int unsigned CFG_PD_BIT   = 2;
    localparam int unsigned ST_SRST_BIT  = 7;
    localparam int unsigned ST_PD_BIT    = 2;
    localparam int unsigned ST_RDY_BIT   = 0;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_OPTION,
        TGT_CFGSTAT,
        TGT_STATUS
    } reg_tgt_e;

    typedef struct packed {
        logic soft_rst;
        logic pwr_dn;
    } ctl_state_t;

    function automatic reg_tgt_e decode_tgt(input logic [OFS_W-1:0] ofs,
                                            input logic upper_clear);
        reg_tgt_e t;
        t = TGT_NONE;
        if (upper_clear) begin
            if (ofs == OFS_OPTION)       t = TGT_OPTION;
            else if (ofs == OFS_CFGSTAT) t = TGT_CFGSTAT;
            else if (ofs == OFS_STATUS)  t = TGT_STATUS;
        end
        return t;
    endfunction

    function automatic logic [7:0] pack_status(input ctl_state_t s, input logic rdy);
        logic [7:0] b;
        b = 8'h00;
        b[ST_SRST_BIT] = s.soft_rst;
        b[ST_PD_BIT]   = s.pwr_dn;
        b[ST_RDY_BIT]  = rdy;
        return b;
    endfunction

endpackage

// File: rtl/cmr_sync_chain.sv
`timescale 1ns/1ps
module cmr_sync_chain #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RST_VALUE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VALUE}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R5: output is the input two edges back, once clear of reset
            p_sync_latency_r5: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/cmr_strobe_edge.sv
`timescale 1ns/1ps
module cmr_strobe_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic rise_pulse
);
    logic strobe_s;
    logic strobe_d;

    cmr_sync_chain #(.STAGES(STAGES), .RST_VALUE(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (strobe_n),
        .q   (strobe_s)
    );

    always_ff @(posedge clk) begin
        if (rst) strobe_d <= 1'b1;
        else     strobe_d <= strobe_s;
    end

    assign rise_pulse = strobe_s & ~strobe_d;

    // R11: one rising edge yields exactly one write pulse
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/cmr_decode.sv
`timescale 1ns/1ps
module cmr_decode
    import cmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 26
) (
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output reg_tgt_e          tgt,
    output logic              qual,
    output logic              rd_drive
);
    logic upper_clear;

    generate
        if (ADDR_W > OFS_W) begin : g_hi
            assign upper_clear = ~|addr[ADDR_W-1:OFS_W];
        end else begin : g_nohi
            assign upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        tgt      = decode_tgt(addr[OFS_W-1:0], upper_clear);
        qual     = ~reg_n & ~ce1_n & ~addr[0];
        rd_drive = qual & ~oe_n;
    end

endmodule

// File: rtl/cmr_regs.sv
`timescale 1ns/1ps
module cmr_regs
    import cmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_pulse,
    input  logic       qual,
    input  reg_tgt_e   tgt,
    input  logic [7:0] wdata,
    output ctl_state_t st
);
    ctl_state_t st_nxt;
    logic       wr_opt;
    logic       wr_cfg;

    always_comb begin
        wr_opt = wr_pulse & qual & (tgt == TGT_OPTION);
        wr_cfg = wr_pulse & qual & (tgt == TGT_CFGSTAT);
        st_nxt = st;
        if (wr_opt) st_nxt.soft_rst = wdata[OPT_SRST_BIT];
        if (wr_cfg) st_nxt.pwr_dn   = wdata[CFG_PD_BIT];
        if (st_nxt.soft_rst) st_nxt.pwr_dn = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nxt;
    end

    // R7: power-down never coexists with soft reset
    p_pd_clear_in_srst_r7: assert property (@(posedge clk) disable iff (rst)
        st.soft_rst |-> !st.pwr_dn);

    // R11: without a write pulse the control state holds
    p_hold_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |=> $stable(st));

    // R3: a qualified power-down write outside soft reset takes effect
    p_pd_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && qual && tgt == TGT_CFGSTAT && !st.soft_rst && wdata[CFG_PD_BIT])
        |=> st.pwr_dn);

    // R2: a qualified option write carries bit 7 into soft reset
    p_srst_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && qual && tgt == TGT_OPTION) |=> (st.soft_rst == $past(wdata[OPT_SRST_BIT])));

endmodule

// File: rtl/cmr_top.sv
`timescale 1ns/1ps
module cmr_top
    import cmr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 26,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_reg_n,
    input  logic              host_ce1_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic [ADDR_W-1:0] host_addr,
    inout  wire  [7:0]        host_d,
    input  logic              mem_rdy,
    output logic              mem_rst,
    output logic              mem_pd
);
    reg_tgt_e   tgt;
    logic       qual;
    logic       rd_drive;
    logic       wr_pulse;
    logic       rdy_s;
    ctl_state_t st;
    logic [7:0] rd_byte;

    cmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_n    (host_reg_n),
        .ce1_n    (host_ce1_n),
        .oe_n     (host_oe_n),
        .addr     (host_addr),
        .tgt      (tgt),
        .qual     (qual),
        .rd_drive (rd_drive)
    );

    cmr_strobe_edge #(.STAGES(SYNC_STAGES)) u_we (
        .clk        (clk),
        .rst        (rst),
        .strobe_n   (host_we_n),
        .rise_pulse (wr_pulse)
    );

    cmr_sync_chain #(.STAGES(SYNC_STAGES), .RST_VALUE(1'b0)) u_rdy (
        .clk (clk),
        .rst (rst),
        .d   (mem_rdy),
        .q   (rdy_s)
    );

    cmr_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .qual     (qual),
        .tgt      (tgt),
        .wdata    (host_d),
        .st       (st)
    );

    always_comb begin
        rd_byte = (tgt == TGT_STATUS) ? pack_status(st, rdy_s) : 8'h00;
    end

    assign host_d  = rd_drive ? rd_byte : 8'bz;
    assign mem_rst = st.soft_rst;
    assign mem_pd  = st.pwr_dn;

    // R4: unused status positions always read 0
    p_status_layout_r4: assert property (@(posedge clk) disable iff (rst)
        ((rd_byte & 8'h7A) == 8'h00));

    // R10: write-only offsets never return data
    p_wo_readback_r10: assert property (@(posedge clk) disable iff (rst)
        (tgt == TGT_OPTION || tgt == TGT_CFGSTAT) |-> (rd_byte == 8'h00));

endmodule

// File: tb/tb_cmr_top.sv
`timescale 1ns/1ps
module tb_cmr_top;
    localparam int unsigned AW = 26;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_n, ce1_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic          rdy;
    logic          mrst, mpd;
    logic [7:0]    tb_drv;
    logic          tb_en;
    wire  [7:0]    bus;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_srst, m_pd;

    assign bus = tb_en ? tb_drv : 8'bz;

    always #2 clk = ~clk;

    cmr_top #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .host_reg_n(reg_n), .host_ce1_n(ce1_n),
        .host_oe_n(oe_n), .host_we_n(we_n), .host_addr(addr), .host_d(bus),
        .mem_rdy(rdy), .mem_rst(mrst), .mem_pd(mpd)
    );

    function automatic logic [7:0] exp_status(bit s, bit p, bit r);
        return {s, 4'b0000, p, 1'b0, r};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [AW-1:0] a, logic [7:0] d, bit rn, bit cn);
        if (!rn && !cn && !a[0]) begin
            if (a == 26'h4000) m_srst = d[7];
            if (a == 26'h4002) m_pd = d[2];
            if (m_srst) m_pd = 1'b0;
        end
    endtask

    task automatic host_write(logic [AW-1:0] a, logic [7:0] d, bit rn, bit cn);
        @(negedge clk);
        addr = a; reg_n = rn; ce1_n = cn; tb_drv = d; tb_en = 1'b1;
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (6) @(negedge clk);
        tb_en = 1'b0; reg_n = 1'b1; ce1_n = 1'b1;
        model_write(a, d, rn, cn);
    endtask

    task automatic host_read(logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; reg_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b0;
        #1 v = bus;
        @(negedge clk);
        oe_n = 1'b1; reg_n = 1'b1; ce1_n = 1'b1;
    endtask

    task automatic check_pins(string req);
        check(req, {6'b0, mrst, mpd}, {6'b0, m_srst, m_pd});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        rst = 1'b1; reg_n = 1'b1; ce1_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        addr = '0; rdy = 1'b1; tb_drv = 8'h00; tb_en = 1'b0;
        m_srst = 1'b0; m_pd = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check_pins("R1 pins");
        host_read(26'h4100, v);
        check("R1 status", v, 8'h01);

        // R11: no effect while we_n held low
        @(negedge clk);
        addr = 26'h4002; reg_n = 1'b0; ce1_n = 1'b0; tb_drv = 8'h04; tb_en = 1'b1;
        we_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 low strobe", {7'b0, mpd}, 8'h00);
        we_n = 1'b1;
        repeat (6) @(negedge clk);
        tb_en = 1'b0; reg_n = 1'b1; ce1_n = 1'b1;
        model_write(26'h4002, 8'h04, 1'b0, 1'b0);
        // R3: power-down set
        check_pins("R3 set");
        host_read(26'h4100, v);
        check("R3 R4 status", v, 8'h05);

        // R10: write-only readback
        host_read(26'h4000, v);
        check("R10 option read", v, 8'h00);
        host_read(26'h4002, v);
        check("R10 config read", v, 8'h00);

        // R5: ready synchronizer latency, read held open
        @(negedge clk);
        addr = 26'h4100; reg_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b0;
        rdy = 1'b0;
        @(negedge clk);
        check("R5 one edge", bus, 8'h05);
        @(negedge clk);
        check("R5 two edges", bus, 8'h04);
        oe_n = 1'b1; reg_n = 1'b1; ce1_n = 1'b1;
        rdy = 1'b1;
        repeat (3) @(negedge clk);

        // R3: power-down clear
        host_write(26'h4002, 8'h00, 1'b0, 1'b0);
        check_pins("R3 clear");

        // R2 and R7: soft reset clears power-down and blocks it
        host_write(26'h4002, 8'h04, 1'b0, 1'b0);
        host_write(26'h4000, 8'h80, 1'b0, 1'b0);
        check("R2 R7 set", {6'b0, mrst, mpd}, 8'h02);
        host_write(26'h4002, 8'h04, 1'b0, 1'b0);
        check("R7 blocked", {6'b0, mrst, mpd}, 8'h02);
        host_read(26'h4100, v);
        check("R2 R4 status", v, 8'h81);
        host_write(26'h4000, 8'h00, 1'b0, 1'b0);
        check("R2 end", {6'b0, mrst, mpd}, 8'h00);

        // R6: unsupported bits ignored
        host_write(26'h4000, 8'h7F, 1'b0, 1'b0);
        check_pins("R6 option low bits");
        host_write(26'h4002, 8'hFB, 1'b0, 1'b0);
        check_pins("R6 config other bits");
        host_read(26'h4100, v);
        check("R6 status", v, 8'h01);

        // R8: unqualified or misaddressed writes ignored
        host_write(26'h4002, 8'h04, 1'b1, 1'b0);
        check("R8 reg_n high", {7'b0, mpd}, 8'h00);
        host_write(26'h4002, 8'h04, 1'b0, 1'b1);
        check("R8 ce1_n high", {7'b0, mpd}, 8'h00);
        host_write(26'h4003, 8'h04, 1'b0, 1'b0);
        check("R8 A0 set", {7'b0, mpd}, 8'h00);
        host_write(26'h4004, 8'h04, 1'b0, 1'b0);
        check("R8 other offset", {7'b0, mpd}, 8'h00);
        host_write(26'h0104002, 8'h04, 1'b0, 1'b0);
        check("R8 high address", {7'b0, mpd}, 8'h00);
        host_write(26'h4100, 8'hFF, 1'b0, 1'b0);
        check("R8 status write", {6'b0, mrst, mpd}, 8'h00);

        // R9: bus drive only on qualified read
        @(negedge clk);
        addr = 26'h4100; reg_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b1;
        #1 check("R9 oe high floats", (bus === 8'bz) ? 8'h01 : 8'h00, 8'h01);
        reg_n = 1'b1; oe_n = 1'b0;
        #1 check("R9 reg_n high floats", (bus === 8'bz) ? 8'h01 : 8'h00, 8'h01);
        reg_n = 1'b0; addr = 26'h4101;
        #1 check("R9 A0 set floats", (bus === 8'bz) ? 8'h01 : 8'h00, 8'h01);
        addr = 26'h4100;
        #1 check("R9 qualified drives", bus, 8'h01);
        oe_n = 1'b1; reg_n = 1'b1; ce1_n = 1'b1;

        // R1: card reset mid-operation
        host_write(26'h4002, 8'h04, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 card reset", {6'b0, mrst, mpd}, 8'h00);
        rst = 1'b0;
        m_srst = 1'b0; m_pd = 1'b0;
        repeat (3) @(negedge clk);

        // R2 R3 R6 R7 R8: seeded random stream against the model
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            logic [7:0]    d;
            bit            rn, cn;
            case ($urandom % 6)
                0, 1: a = 26'h4000;
                2, 3: a = 26'h4002;
                4:    a = 26'h4100;
                default: a = 26'h4002 | (26'd1 << ($urandom % AW));
            endcase
            d  = 8'($urandom);
            rn = (($urandom % 8) == 0);
            cn = (($urandom % 8) == 0);
            host_write(a, d, rn, cn);
            check_pins("R2 R3 R7 R8 random pins");
            rdy = 1'($urandom);
            repeat (3) @(negedge clk);
            host_read(26'h4100, v);
            check("R4 R5 R6 random status", v, exp_status(m_srst, m_pd, rdy));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule